// File: doc/BRIEF.md
# Gray-Coded State Sequencer with Illegal-Transition Detector

The block is a small state machine whose state register holds a reflected Gray code. Each cycle in which the advance enable is high, the state steps to the next code in the cyclic Gray order. With the default 3-bit width the cycle has eight codes.

A second register keeps a copy of the state as it was one cycle earlier. The current state and that copy are compared bit by bit. When two or more bits differ, the step broke the Gray rule that at most one bit changes at a time, and a registered error flag goes high. Correcting the fault is outside the block's task. It only reports the fault.

A test port XORs a mask into the state register so that upsets can be injected on purpose. An upset that lands in the copy register also raises the flag, so the system that reads the flag must allow for false alarms.

Top module: `gray_tx_monitor`

## Requirements
- R1: While rst_ni is low, state_o is 000 and illegal_o is 0.
- R2: With upset_mask_i at 0 and adv_en_i high, state_o steps once per clock through 000, 001, 011, 010, 110, 111, 101, 100 and then returns to 000.
- R3: With upset_mask_i at 0 and adv_en_i low, state_o holds its value and illegal_o stays 0.
- R4: A step that changes zero bits or one bit of state_o never raises illegal_o.
- R5: When state_o differs in two or more bits from its value one clock earlier, illegal_o is 1 for the clock cycle that follows. It is 0 for a clock cycle that follows a step with no such difference.
- R6: A non-zero upset_mask_i is XORed into the value the state register loads at the next clock edge. Bit i of the mask inverts bit i of state_o. This applies whether that value is the held state or the advanced state.
- R7: After an injected upset, advancing continues from the corrupted code along the Gray order. For example, 101 advances to 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_en_i | input | 1 | Advance the state to the next Gray code |
| upset_mask_i | input | W | Test mask XORed into the next state value |
| state_o | output | W | Current Gray-coded state |
| illegal_o | output | 1 | A transition of two or more bits was seen one cycle earlier |

## Verification
The assertions take it as given that any fault reaches the state only through upset_mask_i. On that basis, a clock cycle with a zero mask must produce a legal step, and no mask in the two preceding cycles must mean no flag. The stimulus changes inputs only away from the clock edge. It applies each mask for exactly one cycle and then follows it with zero-mask cycles. This lets each flag be tied to a single injection. The sweep covers every start state, every non-zero 3-bit mask, and injection both with and without a concurrent advance.

// File: rtl/gray_pkg.sv
package gray_pkg;
  localparam int unsigned STATE_W_DEF = 3;

  // true when two or more bits are set
  function automatic logic multi_bit(input logic [31:0] v);
    return (v & (v - 32'd1)) != 32'd0;
  endfunction
endpackage

// File: rtl/gray_state_reg.sv
module gray_state_reg #(
  parameter int unsigned W = gray_pkg::STATE_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_en_i,
  input  logic [W-1:0] upset_mask_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, bin, bin_inc, gray_inc, state_d;

  always_comb begin
    bin[W-1] = state_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ state_q[i];
  end

  assign bin_inc  = bin + W'(1);
  assign gray_inc = bin_inc ^ (bin_inc >> 1);
  assign state_d  = (adv_en_i ? gray_inc : state_q) ^ upset_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_GRAY_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upset_mask_i) == '0 && $past(adv_en_i)) |-> $countones(state_q ^ $past(state_q)) == 1); // R2

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upset_mask_i) == '0 && !$past(adv_en_i)) |-> $stable(state_q)); // R3
endmodule

// File: rtl/last_state_reg.sv
module last_state_reg #(
  parameter int unsigned W = gray_pkg::STATE_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_o <= '0;
    else         last_o <= state_i;
  end
endmodule

// File: rtl/multi_bit_detect.sv
module multi_bit_detect #(
  parameter int unsigned W = gray_pkg::STATE_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] last_i,
  output logic         err_o
);
  logic [W-1:0] diff;
  assign diff = cur_i ^ last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= gray_pkg::multi_bit(32'(diff));
  end
endmodule

// File: rtl/gray_tx_monitor.sv
module gray_tx_monitor #(
  parameter int unsigned W = gray_pkg::STATE_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_en_i,
  input  logic [W-1:0] upset_mask_i,
  output logic [W-1:0] state_o,
  output logic         illegal_o
);
  logic [W-1:0] state_w, last_w;

  gray_state_reg #(.W(W)) u_state (
    .clk_i, .rst_ni, .adv_en_i, .upset_mask_i, .state_o(state_w)
  );

  last_state_reg #(.W(W)) u_last (
    .clk_i, .rst_ni, .state_i(state_w), .last_o(last_w)
  );

  multi_bit_detect #(.W(W)) u_det (
    .clk_i, .rst_ni, .cur_i(state_w), .last_i(last_w), .err_o(illegal_o)
  );

  assign state_o = state_w;

  AST_NO_FALSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upset_mask_i, 2) == '0) |-> !illegal_o); // R4

  AST_SINGLE_UPSET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones($past(upset_mask_i, 2)) == 1 && !$past(adv_en_i, 2)) |-> !illegal_o); // R5
endmodule

// File: tb/gray_tx_monitor_tb.sv
module gray_tx_monitor_tb;
  localparam int W = 3;
  logic clk = 0, rst_ni = 0, adv_en = 0;
  logic [W-1:0] mask = '0;
  logic [W-1:0] state;
  logic illegal;
  int n_vec = 0, n_bad = 0;
  logic [W-1:0] exp_state = '0, exp_last = '0;
  logic exp_err = 0;
  logic [W-1:0] cnt;

  always #5 clk = ~clk;

  gray_tx_monitor #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .adv_en_i(adv_en), .upset_mask_i(mask),
    .state_o(state), .illegal_o(illegal)
  );

  function automatic logic [W-1:0] g_next(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    b = b + 1'b1;
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string tag);
    n_vec++;
    if (state !== exp_state || illegal !== exp_err) begin
      n_bad++;
      $display("FAIL %s: state=%b illegal=%b expected state=%b illegal=%b",
               tag, state, illegal, exp_state, exp_err);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; adv_en = 0; mask = '0;
    @(posedge clk); @(negedge clk);
    exp_state = '0; exp_last = '0; exp_err = 0;
    check("R1");
    rst_ni = 1;
  endtask

  task automatic step(input logic en, input logic [W-1:0] m, input string tag);
    adv_en = en; mask = m;
    @(posedge clk);
    exp_err   = $countones(exp_state ^ exp_last) >= 2;
    exp_last  = exp_state;
    exp_state = (en ? g_next(exp_state) : exp_state) ^ m;
    @(negedge clk);
    check(tag);
    adv_en = 0; mask = '0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R2: explicit code order
    cnt = '0;
    for (int k = 0; k < 16; k++) begin
      cnt = cnt + 1'b1;
      step(1, '0, "R2");
      n_vec++;
      if (state !== (cnt ^ (cnt >> 1))) begin
        n_bad++;
        $display("FAIL R2: state=%b expected %b", state, cnt ^ (cnt >> 1));
      end
    end
    // R3: hold periods at varied states
    for (int k = 0; k < 8; k++) begin
      step(0, '0, "R3");
      step(0, '0, "R3");
      step(1, '0, "R4");
    end
    // R5/R6/R7: every start state, mask, advance flag
    for (int s = 0; s < 8; s++)
      for (int m = 1; m < 8; m++)
        for (int e = 0; e < 2; e++) begin
          do_reset();
          for (int k = 0; k < s; k++) step(1, '0, "R2");
          step(e[0], m[W-1:0], "R6");
          step(1, '0, "R5");
          step(1, '0, "R7");
          step(0, '0, "R5");
          step(1, '0, "R4");
        end
    // R1: reset mid-sequence
    for (int k = 0; k < 5; k++) step(1, '0, "R2");
    do_reset();
    step(1, '0, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule